// File: doc/BRIEF.md
# Indirect Configuration Register Access Bridge

This block gives a host a small window of four 32-bit registers through which it reaches a much larger configuration space that sits behind a simple back-end register port. Software selects a target function (a physical function, one of its virtual functions, or the port's own configuration and status registers). It loads write data if needed and then writes a control word that holds the register address, the direction, per-byte enables and a start bit. The bridge freezes the request, raises a request line on the back-end port and holds it until the back end acknowledges.

The start bit reads back as a busy flag. It stays 1 while the back-end transaction is open and drops to 0 in the same cycle that read data from the back end becomes visible in the read-data register. A virtual function is addressed with the same register offsets as its parent physical function: the address travels to the back end unchanged, and only the function identity fields differ.

Top module: `cfg_ia_bridge`

## Requirements
- R1: Synchronous active-high reset clears all four host registers to zero, drops the busy flag and the back-end request. This also applies in the middle of an open transaction.
- R2: Host register map, by byte offset with bits [3:2] decoded. 0x0 is the function select: type in [2:0], PF number in [12:8], VF number in [26:16]. 0x4 is the control word: busy/start in bit 0, write=1/read=0 in bit 1, byte enables in [7:4], address in [27:8]. 0x8 is write data and 0xC is read data. Undefined bits read 0. A control write with bit 0 clear while idle updates the fields without starting an access.
- R3: A control write with bit 0 set while idle makes bit 0 read 1 from the next cycle. `be_req` rises in that same cycle and stays high, with all request fields unchanged, until the cycle in which `be_ack` is high.
- R4: At the clock edge where `be_req` and `be_ack` are both high, the request drops and the busy bit clears. For a read, `be_rdata` appears in the read-data register at that same edge. A write leaves the read-data register unchanged.
- R5: While busy, any host write to the control word is ignored. No second request is issued, and the control fields keep their values.
- R6: Function type 1 forwards both the PF and VF numbers. Any type other than 1 and 2 forwards the PF number with the VF field driven 0.
- R7: Function type 2 selects the port registers. The PF and VF fields on the back-end port are driven 0 whatever the function select holds.
- R8: The back-end address equals the control-word address field unchanged, for every function type.
- R9: A write carries the byte enables on `be_byte_en`. Byte lanes whose enable is 0 are driven 0 on `be_wdata`, so only enabled lanes change the target.
- R10: Host writes to offset 0xC do not change the read-data register.
- R11: Function select and write data are captured at start. Host writes to them while busy do not alter the open request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe (one-cycle access) |
| host_addr | input | 4 | Host byte offset, bits [3:2] select the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| be_req | output | 1 | Back-end request, held until acknowledged |
| be_write | output | 1 | Back-end direction, 1 = write |
| be_addr | output | ADDR_W | Back-end register address |
| be_fn_type | output | 3 | Function type of the request |
| be_pf | output | 5 | Physical-function number |
| be_vf | output | 11 | Virtual-function number |
| be_byte_en | output | 4 | Back-end byte enables |
| be_wdata | output | 32 | Back-end write data, disabled lanes zero |
| be_ack | input | 1 | Back-end acknowledge |
| be_rdata | input | 32 | Back-end read data, valid with be_ack |

## Verification
The assertions assume the back end raises `be_ack` only while `be_req` is high, holds it for one cycle, and keeps `be_rdata` valid in that cycle. The bench's back-end model follows this rule. It drives both signals only after seeing the request, clears the acknowledge on the next cycle, and varies its latency from zero to eight cycles. The host side follows the software discipline: one register access per cycle, a new start only after bit 0 has read 0, and write data loaded before the control word. The one exception is deliberate, where the bench writes the control word while busy to show that the write has no effect.

// File: rtl/cfg_ia_bridge.sv
module cfg_ia_bridge #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [3:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              be_req,
  output logic              be_write,
  output logic [ADDR_W-1:0] be_addr,
  output logic [2:0]        be_fn_type,
  output logic [4:0]        be_pf,
  output logic [10:0]       be_vf,
  output logic [3:0]        be_byte_en,
  output logic [31:0]       be_wdata,
  input  logic              be_ack,
  input  logic [31:0]       be_rdata
);

  localparam int ADDR_LO = 8;
  localparam int ADDR_HI = ADDR_LO + ADDR_W - 1;
  localparam int PAD_W   = 31 - ADDR_HI;
  localparam logic [2:0] TYPE_VF   = 3'd1;
  localparam logic [2:0] TYPE_PORT = 3'd2;

  logic [2:0]        sel_type_q;
  logic [4:0]        sel_pf_q;
  logic [10:0]       sel_vf_q;
  logic [31:0]       wdata_q;
  logic [31:0]       rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        ben_q;
  logic              wr_q;
  logic              busy_q;
  logic [2:0]        req_type_q;
  logic [4:0]        req_pf_q;
  logic [10:0]       req_vf_q;
  logic [31:0]       req_wdata_q;

  wire [1:0] reg_sel  = host_addr[3:2];
  wire       wr_sel   = host_we && reg_sel == 2'd0;
  wire       wr_ctrl  = host_we && reg_sel == 2'd1 && !busy_q;
  wire       wr_wdata = host_we && reg_sel == 2'd2;
  wire       start    = wr_ctrl && host_wdata[0];
  wire       done     = busy_q && be_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_type_q  <= '0;
      sel_pf_q    <= '0;
      sel_vf_q    <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      addr_q      <= '0;
      ben_q       <= '0;
      wr_q        <= 1'b0;
      busy_q      <= 1'b0;
      req_type_q  <= '0;
      req_pf_q    <= '0;
      req_vf_q    <= '0;
      req_wdata_q <= '0;
    end else begin
      if (wr_sel) begin
        sel_type_q <= host_wdata[2:0];
        sel_pf_q   <= host_wdata[12:8];
        sel_vf_q   <= host_wdata[26:16];
      end
      if (wr_wdata) wdata_q <= host_wdata;
      if (wr_ctrl) begin
        wr_q   <= host_wdata[1];
        ben_q  <= host_wdata[7:4];
        addr_q <= host_wdata[ADDR_HI:ADDR_LO];
      end
      if (start) begin
        busy_q      <= 1'b1;
        req_type_q  <= sel_type_q;
        req_pf_q    <= (sel_type_q == TYPE_PORT) ? 5'd0 : sel_pf_q;
        req_vf_q    <= (sel_type_q == TYPE_VF) ? sel_vf_q : 11'd0;
        req_wdata_q <= wdata_q;
      end else if (done) begin
        busy_q <= 1'b0;
        if (!wr_q) rdata_q <= be_rdata;
      end
    end
  end

  assign be_req     = busy_q;
  assign be_write   = wr_q;
  assign be_addr    = addr_q;
  assign be_fn_type = req_type_q;
  assign be_pf      = req_pf_q;
  assign be_vf      = req_vf_q;
  assign be_byte_en = ben_q;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign be_wdata[8*i +: 8] = ben_q[i] ? req_wdata_q[8*i +: 8] : 8'h00;
  end

  always_comb begin
    case (reg_sel)
      2'd0:    host_rdata = {5'd0, sel_vf_q, 3'd0, sel_pf_q, 5'd0, sel_type_q};
      2'd1:    host_rdata = {{PAD_W{1'b0}}, addr_q, ben_q, 2'b00, wr_q, busy_q};
      2'd2:    host_rdata = wdata_q;
      default: host_rdata = rdata_q;
    endcase
  end

endmodule

// File: rtl/cfg_ia_bridge_chk.sv
module cfg_ia_bridge_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [3:0]        host_addr,
  input logic [31:0]       host_rdata,
  input logic              be_req,
  input logic              be_write,
  input logic [ADDR_W-1:0] be_addr,
  input logic [2:0]        be_fn_type,
  input logic [4:0]        be_pf,
  input logic [10:0]       be_vf,
  input logic [3:0]        be_byte_en,
  input logic [31:0]       be_wdata,
  input logic              be_ack
);

  function automatic logic [31:0] lane_mask(input logic [3:0] en);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{en[i]}};
    return m;
  endfunction

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !be_req); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    be_req && !be_ack |=> be_req); // R3

  AST_BUSY_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    host_addr[3:2] == 2'd1 |-> host_rdata[0] == be_req); // R3

  AST_ACK_DONE: assert property (@(posedge clk) disable iff (rst)
    be_req && be_ack |=> !be_req); // R4

  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    be_req && !be_ack |=> $stable(be_addr) && $stable(be_write) && $stable(be_byte_en)
      && $stable(be_wdata) && $stable(be_fn_type) && $stable(be_pf) && $stable(be_vf)); // R5

  AST_VF_ONLY_TYPE1: assert property (@(posedge clk) disable iff (rst)
    be_req && be_fn_type != 3'd1 |-> be_vf == 11'd0); // R6

  AST_PORT_NO_IDS: assert property (@(posedge clk) disable iff (rst)
    be_req && be_fn_type == 3'd2 |-> be_pf == 5'd0 && be_vf == 11'd0); // R7

  AST_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    be_req && be_write |-> (be_wdata & ~lane_mask(be_byte_en)) == 32'd0); // R9

endmodule

bind cfg_ia_bridge cfg_ia_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .host_rdata(host_rdata), .be_req(be_req), .be_write(be_write),
  .be_addr(be_addr), .be_fn_type(be_fn_type), .be_pf(be_pf), .be_vf(be_vf),
  .be_byte_en(be_byte_en), .be_wdata(be_wdata), .be_ack(be_ack)
);

// File: tb/cfg_ia_bridge_bench.sv
`timescale 1ns/1ps
module cfg_ia_bridge_bench;
  localparam int AW = 20;
  localparam logic [31:0] CTRL_MASK = 32'h0FFF_FF00 | 32'hF2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic be_req, be_write;
  logic [AW-1:0] be_addr;
  logic [2:0] be_fn_type;
  logic [4:0] be_pf;
  logic [10:0] be_vf;
  logic [3:0] be_byte_en;
  logic [31:0] be_wdata;
  logic be_ack = 1'b0;
  logic [31:0] be_rdata = '0;

  always #5 clk = ~clk;

  cfg_ia_bridge #(.ADDR_W(AW)) u_cfg_ia_bridge (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .be_req(be_req),
    .be_write(be_write), .be_addr(be_addr), .be_fn_type(be_fn_type),
    .be_pf(be_pf), .be_vf(be_vf), .be_byte_en(be_byte_en),
    .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] seed(input logic [38:0] k);
    return (k[31:0] * 32'h9E37_79B1) ^ {25'd0, k[38:32]} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mask_of(input logic [3:0] en);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{en[i]}};
    return m;
  endfunction

  // back-end register model
  logic [31:0] mem [logic [38:0]];
  logic [31:0] exp_mem [logic [38:0]];
  int bk_delay = 0;
  int wcnt = 0;
  bit prev_req = 0;
  int req_count = 0;
  logic [AW-1:0] cap_addr;
  logic [2:0] cap_type;
  logic [4:0] cap_pf;
  logic [10:0] cap_vf;
  logic [3:0] cap_be;
  logic [31:0] cap_wdata;
  logic cap_write;

  always @(negedge clk) begin
    if (rst) begin
      be_ack = 1'b0;
      wcnt = 0;
      prev_req = 0;
    end else begin
      if (be_req && !prev_req) begin
        req_count++;
        cap_addr = be_addr; cap_type = be_fn_type; cap_pf = be_pf;
        cap_vf = be_vf; cap_be = be_byte_en; cap_wdata = be_wdata; cap_write = be_write;
      end
      prev_req = be_req;
      if (be_ack) be_ack = 1'b0;
      else if (be_req) begin
        if (wcnt >= bk_delay) begin
          logic [38:0] k;
          logic [31:0] cur;
          k = {be_fn_type, be_pf, be_vf, be_addr};
          cur = mem.exists(k) ? mem[k] : seed(k);
          if (be_write) mem[k] = (cur & ~mask_of(be_byte_en)) | (be_wdata & mask_of(be_byte_en));
          else be_rdata = cur;
          be_ack = 1'b1;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic logic [38:0] exp_key(input logic [2:0] t, input logic [4:0] pf,
                                          input logic [10:0] vf, input logic [AW-1:0] a);
    logic [4:0] p = (t == 3'd2) ? 5'd0 : pf;
    logic [10:0] v = (t == 3'd1) ? vf : 11'd0;
    return {t, p, v, a};
  endfunction

  task automatic prog_start(input logic [2:0] t, input logic [4:0] pf, input logic [10:0] vf,
                            input logic [AW-1:0] a, input bit wr, input logic [3:0] en,
                            input logic [31:0] d);
    logic [31:0] v;
    logic [31:0] cw;
    host_write(4'h0, {5'h1F, vf, 3'h7, pf, 5'h1F, t});
    host_read(4'h0, v);
    chk(v == {5'd0, vf, 3'd0, pf, 5'd0, t}, "R2 fnsel readback", v, {5'd0, vf, 3'd0, pf, 5'd0, t});
    host_write(4'h8, d);
    cw = {4'hF, a, en, 2'b11, wr, 1'b1};
    host_write(4'h4, cw);
    host_read(4'h4, v);
    chk(v[0] == 1'b1, "R3 busy after start", v[0], 1);
    chk((v & ~32'd1) == (cw & CTRL_MASK), "R2 ctrl readback", v, cw & CTRL_MASK);
  endtask

  task automatic wait_idle(output logic [31:0] rd);
    logic [31:0] v;
    v = 32'd1;
    for (int i = 0; i < 40 && v[0]; i++) begin
      @(negedge clk);
      host_read(4'h4, v);
    end
    chk(v[0] == 1'b0, "R4 busy clears", v[0], 0);
    host_read(4'hC, rd);
  endtask

  task automatic access(input logic [2:0] t, input logic [4:0] pf, input logic [10:0] vf,
                        input logic [AW-1:0] a, input bit wr, input logic [3:0] en,
                        input logic [31:0] d);
    logic [38:0] k;
    logic [31:0] rd, old_rd, cur;
    int n0;
    k = exp_key(t, pf, vf, a);
    cur = exp_mem.exists(k) ? exp_mem[k] : seed(k);
    host_read(4'hC, old_rd);
    n0 = req_count;
    prog_start(t, pf, vf, a, wr, en, d);
    wait_idle(rd);
    chk(req_count == n0 + 1, "R3 one request", req_count, n0 + 1);
    chk(cap_addr == a, "R8 address unchanged", cap_addr, a);
    chk(cap_type == t && cap_write == wr, "R3 type/direction", {cap_type, cap_write}, {t, wr});
    if (t == 3'd2)
      chk(cap_pf == 0 && cap_vf == 0, "R7 port ids zero", {cap_pf, cap_vf}, 0);
    else
      chk({cap_pf, cap_vf} == {pf, (t == 3'd1) ? vf : 11'd0}, "R6 function id",
          {cap_pf, cap_vf}, {pf, (t == 3'd1) ? vf : 11'd0});
    if (wr) begin
      chk(cap_be == en, "R9 byte enables", cap_be, en);
      chk(cap_wdata == (d & mask_of(en)), "R9 lane data", cap_wdata, d & mask_of(en));
      chk(rd == old_rd, "R4 write keeps rdata", rd, old_rd);
      exp_mem[k] = (cur & ~mask_of(en)) | (d & mask_of(en));
    end else begin
      chk(rd == cur, "R4 read data at done", rd, cur);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, rd;
    logic [2:0] types [4] = '{3'd0, 3'd1, 3'd2, 3'd5};
    logic [4:0] pfs [3] = '{5'd0, 5'd1, 5'd31};
    logic [10:0] vfs [3] = '{11'd0, 11'd2, 11'd2047};
    logic [AW-1:0] addrs [3] = '{20'h00004, 20'h1414C, 20'hFFFFF};
    int n;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 4; r++) begin
      host_read(4'(r * 4), v);
      chk(v == 0, "R1 reset register value", v, 0);
    end
    chk(be_req == 1'b0, "R1 no request after reset", be_req, 0);

    // R2: control write without start only updates fields
    host_write(4'h4, {4'h0, 20'h1234, 4'h5, 2'b00, 1'b1, 1'b0});
    host_read(4'h4, v);
    chk(v == {4'h0, 20'h1234, 4'h5, 2'b00, 1'b1, 1'b0}, "R2 ctrl no start", v, {4'h0, 20'h1234, 4'h5, 4'b0010});
    repeat (3) @(negedge clk);
    chk(req_count == 0, "R2 no request without start", req_count, 0);

    // sweep: write then read back every function/address combination
    n = 0;
    foreach (types[ti]) foreach (pfs[pi]) foreach (vfs[vi]) foreach (addrs[ai]) begin
      bk_delay = n % 4;
      access(types[ti], pfs[pi], vfs[vi], addrs[ai], 1'b1, 4'(n % 16), 32'hA5C3_0000 + 32'(n * 97));
      bk_delay = (n + 1) % 4;
      access(types[ti], pfs[pi], vfs[vi], addrs[ai], 1'b0, 4'h0, 32'd0);
      n++;
    end

    // R7: port type ignores ids; a write under other ids reads back under ids zero
    bk_delay = 1;
    access(3'd2, 5'd9, 11'd77, 20'h1414C, 1'b1, 4'hF, 32'hCAFE_F00D);
    access(3'd2, 5'd0, 11'd0, 20'h1414C, 1'b0, 4'h0, 32'd0);

    // R10: write to read-data offset ignored
    host_read(4'hC, rd);
    host_write(4'hC, ~rd);
    host_read(4'hC, v);
    chk(v == rd, "R10 rdata write ignored", v, rd);

    // R5 + R11: ctrl/fnsel/wdata writes while busy
    bk_delay = 8;
    n = req_count;
    prog_start(3'd1, 5'd3, 11'd5, 20'h00010, 1'b1, 4'hF, 32'h1111_2222);
    host_write(4'h4, {4'h0, 20'h00020, 4'h3, 2'b00, 1'b0, 1'b1});
    host_write(4'h8, 32'h9999_8888);
    host_write(4'h0, {5'd0, 11'd6, 3'd0, 5'd4, 5'd0, 3'd1});
    host_read(4'h4, v);
    chk(v[27:8] == 20'h00010 && v[1] == 1'b1 && v[7:4] == 4'hF, "R5 ctrl unchanged while busy",
        v, {4'h0, 20'h00010, 4'hF, 4'b0011});
    wait_idle(rd);
    chk(req_count == n + 1, "R5 no extra request", req_count, n + 1);
    repeat (4) @(negedge clk);
    chk(req_count == n + 1, "R5 no late request", req_count, n + 1);
    exp_mem[exp_key(3'd1, 5'd3, 11'd5, 20'h00010)] = 32'h1111_2222;
    chk(cap_wdata == 32'h1111_2222 && cap_pf == 5'd3 && cap_vf == 11'd5, "R11 snapshot at start",
        {cap_pf, cap_vf, cap_wdata}, {5'd3, 11'd5, 32'h1111_2222});
    bk_delay = 0;
    access(3'd1, 5'd3, 11'd5, 20'h00010, 1'b0, 4'h0, 32'd0);

    // R1: reset during an open transaction
    bk_delay = 8;
    prog_start(3'd0, 5'd2, 11'd0, 20'h00040, 1'b0, 4'h0, 32'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(be_req == 1'b0, "R1 reset drops request", be_req, 0);
    host_read(4'h4, v);
    chk(v == 0, "R1 reset clears ctrl", v, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule